// File: doc/BRIEF.md
# Register Dependency Scheduler

This block receives a window of decoded instructions, listed oldest first. Each instruction names one destination register and two source registers, and each of the three has its own valid flag. The block compares every younger instruction against every older one on register names. It works out which read/write orderings link the pair and turns them into timing limits. From those limits it gives every instruction an issue cycle and an execution unit, for a chosen number of parallel units. An instruction that consumes a result is steered onto the unit that produced it, so the chain stays in order and can use bypassing. An instruction that is free of all limits takes the earliest free slot. Such an instruction may therefore move ahead of older instructions that are waiting.

A one-cycle `start` pulse captures the window. The block then handles one instruction per clock, and a one-cycle `done` pulse marks the end. The schedule outputs keep their values until the next accepted start. Register names are the only input to the schedule. Latencies, bypass paths and memory addresses play no part.

Top module: `regdep_scheduler`

## Requirements
- R1: A `start` seen while the block is idle captures the whole window. `done` is then high for exactly one cycle, starting at the N_INST-th rising edge after the edge that sampled `start`. Instruction k (k = 0 is the oldest) occupies bits [k*REG_W +: REG_W] of each register input and bit k of each valid input. Its results sit at `issueCycle[k*CYC_W +: CYC_W]` and `issueUnit[k*UNIT_W +: UNIT_W]`.
- R2: When two instructions only read the same register, neither is held back. An instruction with no limit from any older instruction takes the lowest cycle that has a free unit, and the lowest-numbered free unit in that cycle. This holds even if older instructions issue later.
- R3: If a younger instruction reads a register that an older one writes, it issues in a strictly later cycle than the older one. It also issues on the older one's unit. When several older writers feed it, the unit of the youngest of them is used.
- R4: If a younger instruction writes a register that an older one reads, it issues in the same cycle as the older one or later, never earlier. Taking the same cycle is allowed.
- R5: If both instructions write the same register, the younger one issues no earlier than the older one.
- R6: Each unit takes at most one instruction per cycle. A steered instruction whose unit is busy in its earliest cycle takes that unit's next free cycle. Every unit index is below NUM_UNITS.
- R7: A register field whose valid flag is 0 is ignored. A store-like instruction that has no destination therefore creates no read-after-write or write-after-write dependency, and an invalid source creates no read-after-write dependency.
- R8: `totalCycles` equals the largest issue cycle in the window plus one.
- R9: The schedule outputs and `totalCycles` hold their values from `done` until the next accepted start, whatever the window inputs do meanwhile. A `start` that arrives during a computation is ignored, and the window captured first is the one scheduled.
- R10: After reset, `done` is 0 and all issue cycles, unit indices and `totalCycles` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the window and begin scheduling |
| instDst | input | N_INST*REG_W | Destination register of each instruction |
| instDstValid | input | N_INST | Destination present |
| instSrcA | input | N_INST*REG_W | First source register |
| instSrcAValid | input | N_INST | First source present |
| instSrcB | input | N_INST*REG_W | Second source register |
| instSrcBValid | input | N_INST | Second source present |
| done | output | 1 | One-cycle pulse when the schedule is ready |
| issueCycle | output | N_INST*CYC_W | Issue cycle of each instruction |
| issueUnit | output | N_INST*UNIT_W | Execution unit of each instruction |
| totalCycles | output | TOT_W | Number of cycles the window needs |

## Verification
The block keeps a record of which unit is busy in which cycle. If that record is wrong, two instructions end up sharing a unit in one cycle, or a steered instruction is pushed past its proper slot. Either fault shows at the ports in the same cycle as `done`. A dependency that is missed or misread shows as an issue cycle that is too early or a unit that breaks the chain, and it also shows when `done` rises. Because every later instruction is placed against the earlier ones, one wrong placement usually moves several of the following results as well. The bench uses hand-worked windows whose answers differ whenever a single rule is dropped.

// File: rtl/regdep_sched_pkg.sv
`timescale 1ns/1ps
package regdep_sched_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture window, clear occupancy and total
    logic step;   // place the instruction selected by stepIdx
  } ctrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_t;

  // ordering constraints one older instruction places on a younger one
  typedef struct packed {
    logic raw;    // older writes, younger reads
    logic war;    // older reads, younger writes
    logic waw;    // both write
  } dep_t;

endpackage

// File: rtl/regdep_sched_ctrl.sv
`timescale 1ns/1ps
module regdep_sched_ctrl
  import regdep_sched_pkg::*;
#(
  parameter int N_INST = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrl_t            ctrl,
  output logic [IDX_W-1:0] stepIdx,
  output logic             done
);

  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(N_INST - 1);

  state_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepIdx <= '0;
          end
        end
        ST_RUN: begin
          if (stepIdx == LastIdx) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            stepIdx <= stepIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load = (state == ST_IDLE) && start;
    ctrl.step = (state == ST_RUN);
  end

endmodule

// File: rtl/regdep_sched_dpath.sv
`timescale 1ns/1ps
module regdep_sched_dpath
  import regdep_sched_pkg::*;
#(
  parameter int N_INST    = 8,
  parameter int REG_W     = 5,
  parameter int NUM_UNITS = 2,
  parameter int IDX_W     = 3,
  parameter int CYC_W     = 3,
  parameter int UNIT_W    = 1,
  parameter int TOT_W     = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_t                     ctrl,
  input  logic [IDX_W-1:0]          stepIdx,
  input  logic [N_INST*REG_W-1:0]   instDst,
  input  logic [N_INST-1:0]         instDstValid,
  input  logic [N_INST*REG_W-1:0]   instSrcA,
  input  logic [N_INST-1:0]         instSrcAValid,
  input  logic [N_INST*REG_W-1:0]   instSrcB,
  input  logic [N_INST-1:0]         instSrcBValid,
  output logic [N_INST*CYC_W-1:0]   issueCycle,
  output logic [N_INST*UNIT_W-1:0]  issueUnit,
  output logic [TOT_W-1:0]          totalCycles
);

  // captured window
  logic [N_INST*REG_W-1:0] dstQ, srcAQ, srcBQ;
  logic [N_INST-1:0]       dstVQ, srcAVQ, srcBVQ;

  // placement results and unit occupancy (unit x cycle)
  logic [CYC_W-1:0]  cycQ   [N_INST];
  logic [UNIT_W-1:0] unitQ  [N_INST];
  logic [N_INST-1:0] busyQ  [NUM_UNITS];
  logic [TOT_W-1:0]  totalQ;

  // current instruction fields
  logic [REG_W-1:0] curDst, curSrcA, curSrcB;
  logic             curDstV, curSrcAV, curSrcBV;

  // constraint gathering and slot search
  dep_t              depJ;
  logic [TOT_W-1:0]  earliest;
  logic              pinned;
  logic [UNIT_W-1:0] pinUnit;
  logic              found;
  logic [CYC_W-1:0]  pickCyc;
  logic [UNIT_W-1:0] pickUnit;

  function automatic dep_t classify(
    input logic [REG_W-1:0] oDst, input logic oDstV,
    input logic [REG_W-1:0] oSrcA, input logic oSrcAV,
    input logic [REG_W-1:0] oSrcB, input logic oSrcBV,
    input logic [REG_W-1:0] yDst, input logic yDstV,
    input logic [REG_W-1:0] ySrcA, input logic ySrcAV,
    input logic [REG_W-1:0] ySrcB, input logic ySrcBV
  );
    dep_t d;
    d.raw = oDstV && ((ySrcAV && (ySrcA == oDst)) || (ySrcBV && (ySrcB == oDst)));
    d.war = yDstV && ((oSrcAV && (oSrcA == yDst)) || (oSrcBV && (oSrcB == yDst)));
    d.waw = yDstV && oDstV && (yDst == oDst);
    return d;
  endfunction

  always_comb begin
    curDst   = dstQ[stepIdx*REG_W +: REG_W];
    curSrcA  = srcAQ[stepIdx*REG_W +: REG_W];
    curSrcB  = srcBQ[stepIdx*REG_W +: REG_W];
    curDstV  = dstVQ[stepIdx];
    curSrcAV = srcAVQ[stepIdx];
    curSrcBV = srcBVQ[stepIdx];

    depJ     = '0;
    earliest = '0;
    pinned   = 1'b0;
    pinUnit  = '0;
    for (int j = 0; j < N_INST; j++) begin
      if (j < int'(stepIdx)) begin
        depJ = classify(dstQ[j*REG_W +: REG_W], dstVQ[j],
                        srcAQ[j*REG_W +: REG_W], srcAVQ[j],
                        srcBQ[j*REG_W +: REG_W], srcBVQ[j],
                        curDst, curDstV, curSrcA, curSrcAV, curSrcB, curSrcBV);
        if (depJ.raw) begin
          if (TOT_W'(cycQ[j]) + TOT_W'(1) > earliest)
            earliest = TOT_W'(cycQ[j]) + TOT_W'(1);
          pinned  = 1'b1;
          pinUnit = unitQ[j];          // youngest producer wins
        end else if (depJ.war || depJ.waw) begin
          if (TOT_W'(cycQ[j]) > earliest)
            earliest = TOT_W'(cycQ[j]);
        end
      end
    end
  end

  always_comb begin
    found    = 1'b0;
    pickCyc  = '0;
    pickUnit = '0;
    for (int c = 0; c < N_INST; c++) begin
      if (!found && (c >= int'(earliest))) begin
        if (pinned) begin
          if (!busyQ[pinUnit][c]) begin
            found    = 1'b1;
            pickCyc  = CYC_W'(c);
            pickUnit = pinUnit;
          end
        end else begin
          for (int u = 0; u < NUM_UNITS; u++) begin
            if (!found && !busyQ[u][c]) begin
              found    = 1'b1;
              pickCyc  = CYC_W'(c);
              pickUnit = UNIT_W'(u);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstQ   <= '0;
      srcAQ  <= '0;
      srcBQ  <= '0;
      dstVQ  <= '0;
      srcAVQ <= '0;
      srcBVQ <= '0;
      totalQ <= '0;
      for (int k = 0; k < N_INST; k++) begin
        cycQ[k]  <= '0;
        unitQ[k] <= '0;
      end
      for (int u = 0; u < NUM_UNITS; u++) busyQ[u] <= '0;
    end else begin
      if (ctrl.load) begin
        dstQ   <= instDst;
        srcAQ  <= instSrcA;
        srcBQ  <= instSrcB;
        dstVQ  <= instDstValid;
        srcAVQ <= instSrcAValid;
        srcBVQ <= instSrcBValid;
        totalQ <= '0;
        for (int u = 0; u < NUM_UNITS; u++) busyQ[u] <= '0;
      end
      if (ctrl.step) begin
        cycQ[stepIdx]            <= pickCyc;
        unitQ[stepIdx]           <= pickUnit;
        busyQ[pickUnit][pickCyc] <= 1'b1;
        if (TOT_W'(pickCyc) + TOT_W'(1) > totalQ)
          totalQ <= TOT_W'(pickCyc) + TOT_W'(1);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < N_INST; k++) begin
      issueCycle[k*CYC_W +: CYC_W]  = cycQ[k];
      issueUnit[k*UNIT_W +: UNIT_W] = unitQ[k];
    end
    totalCycles = totalQ;
  end

endmodule

// File: rtl/regdep_scheduler.sv
`timescale 1ns/1ps
module regdep_scheduler
  import regdep_sched_pkg::*;
#(
  parameter int N_INST      = 8,
  parameter int REG_W       = 5,
  parameter int NUM_UNITS   = 2,
  localparam int IDX_W      = (N_INST > 1) ? $clog2(N_INST) : 1,
  localparam int CYC_W      = IDX_W,
  localparam int UNIT_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int TOT_W      = $clog2(N_INST + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [N_INST*REG_W-1:0]   instDst,
  input  logic [N_INST-1:0]         instDstValid,
  input  logic [N_INST*REG_W-1:0]   instSrcA,
  input  logic [N_INST-1:0]         instSrcAValid,
  input  logic [N_INST*REG_W-1:0]   instSrcB,
  input  logic [N_INST-1:0]         instSrcBValid,
  output logic                      done,
  output logic [N_INST*CYC_W-1:0]   issueCycle,
  output logic [N_INST*UNIT_W-1:0]  issueUnit,
  output logic [TOT_W-1:0]          totalCycles
);

  ctrl_t            ctrl;
  logic [IDX_W-1:0] stepIdx;

  regdep_sched_ctrl #(
    .N_INST (N_INST),
    .IDX_W  (IDX_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctrl    (ctrl),
    .stepIdx (stepIdx),
    .done    (done)
  );

  regdep_sched_dpath #(
    .N_INST    (N_INST),
    .REG_W     (REG_W),
    .NUM_UNITS (NUM_UNITS),
    .IDX_W     (IDX_W),
    .CYC_W     (CYC_W),
    .UNIT_W    (UNIT_W),
    .TOT_W     (TOT_W)
  ) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .stepIdx       (stepIdx),
    .instDst       (instDst),
    .instDstValid  (instDstValid),
    .instSrcA      (instSrcA),
    .instSrcAValid (instSrcAValid),
    .instSrcB      (instSrcB),
    .instSrcBValid (instSrcBValid),
    .issueCycle    (issueCycle),
    .issueUnit     (issueUnit),
    .totalCycles   (totalCycles)
  );

endmodule

// File: rtl/regdep_scheduler_chk.sv
`timescale 1ns/1ps
module regdep_scheduler_chk #(
  parameter int N_INST    = 8,
  parameter int NUM_UNITS = 2,
  parameter int CYC_W     = 3,
  parameter int UNIT_W    = 1,
  parameter int TOT_W     = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     start,
  input logic                     done,
  input logic [N_INST*CYC_W-1:0]  issueCycle,
  input logic [N_INST*UNIT_W-1:0] issueUnit,
  input logic [TOT_W-1:0]         totalCycles
);

  // independent model of the run window, counted in edges
  logic           chkRun;
  logic [TOT_W:0] chkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkRun <= 1'b0;
      chkCnt <= '0;
    end else if (start && (!chkRun || done)) begin
      chkRun <= 1'b1;
      chkCnt <= '0;
    end else if (done) begin
      chkRun <= 1'b0;
    end else if (chkRun) begin
      chkCnt <= chkCnt + 1'b1;
    end
  end

  logic             slotsDistinct;
  logic             unitsInRange;
  logic [TOT_W-1:0] maxPlusOne;

  always_comb begin
    slotsDistinct = 1'b1;
    unitsInRange  = 1'b1;
    maxPlusOne    = '0;
    for (int a = 0; a < N_INST; a++) begin
      if (int'(issueUnit[a*UNIT_W +: UNIT_W]) >= NUM_UNITS) unitsInRange = 1'b0;
      if (TOT_W'(issueCycle[a*CYC_W +: CYC_W]) + TOT_W'(1) > maxPlusOne)
        maxPlusOne = TOT_W'(issueCycle[a*CYC_W +: CYC_W]) + TOT_W'(1);
      for (int b = a + 1; b < N_INST; b++) begin
        if ((issueCycle[a*CYC_W +: CYC_W] == issueCycle[b*CYC_W +: CYC_W]) &&
            (issueUnit[a*UNIT_W +: UNIT_W] == issueUnit[b*UNIT_W +: UNIT_W]))
          slotsDistinct = 1'b0;
      end
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (chkRun && (chkCnt == (TOT_W+1)'(N_INST))));

  p_slot_unique_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (slotsDistinct && unitsInRange));

  p_total_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (totalCycles == maxPlusOne));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!chkRun && !start) |=> ($stable(issueCycle) && $stable(issueUnit) && $stable(totalCycles)));

endmodule

bind regdep_scheduler regdep_scheduler_chk #(
  .N_INST    (N_INST),
  .NUM_UNITS (NUM_UNITS),
  .CYC_W     (CYC_W),
  .UNIT_W    (UNIT_W),
  .TOT_W     (TOT_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .done        (done),
  .issueCycle  (issueCycle),
  .issueUnit   (issueUnit),
  .totalCycles (totalCycles)
);

// File: tb/regdep_scheduler_tb_top.sv
`timescale 1ns/1ps
module regdep_scheduler_tb_top;

  localparam int N   = 8;
  localparam int RW  = 5;
  localparam int CW  = 3;
  localparam int UW  = 1;
  localparam int UW4 = 2;
  localparam int TW  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rstN;
  logic          start, start4;
  logic [N*RW-1:0] dst, sa, sb;
  logic [N-1:0]    dv, av, bv;
  logic            done, done4;
  logic [N*CW-1:0] cyc, cyc4;
  logic [N*UW-1:0] unit;
  logic [N*UW4-1:0] unit4;
  logic [TW-1:0]   tot, tot4;

  int checks = 0;
  int errors = 0;

  int    qCyc[$];
  int    qUnit[$];
  string qReq[$];
  int    qTot[$];
  logic  recheck = 1'b0;

  regdep_scheduler dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .instDst(dst), .instDstValid(dv),
    .instSrcA(sa), .instSrcAValid(av),
    .instSrcB(sb), .instSrcBValid(bv),
    .done(done), .issueCycle(cyc), .issueUnit(unit), .totalCycles(tot)
  );

  regdep_scheduler #(.NUM_UNITS(4)) dut_w4_i (
    .clk(clk), .rstN(rstN), .start(start4),
    .instDst(dst), .instDstValid(dv),
    .instSrcA(sa), .instSrcAValid(av),
    .instSrcB(sb), .instSrcBValid(bv),
    .done(done4), .issueCycle(cyc4), .issueUnit(unit4), .totalCycles(tot4)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearWin();
    dst = '0; sa = '0; sb = '0; dv = '0; av = '0; bv = '0;
  endtask

  task automatic setI(input int k, input bit d_v, input int d,
                      input bit a_v, input int a, input bit b_v, input int b);
    dv[k] = d_v; dst[k*RW +: RW] = RW'(d);
    av[k] = a_v; sa[k*RW +: RW]  = RW'(a);
    bv[k] = b_v; sb[k*RW +: RW]  = RW'(b);
  endtask

  task automatic pushWin(input int c[N], input int u[N], input int t, input string req);
    for (int k = 0; k < N; k++) begin
      qCyc.push_back(c[k]);
      qUnit.push_back(u[k]);
      qReq.push_back(req);
    end
    qTot.push_back(t);
  endtask

  // monitor: pops expectations whenever a result is presented
  always @(negedge clk) begin
    if (rstN && (done || recheck)) begin
      if (qTot.size() == 0) begin
        chk(1'b0, "R1", "unexpected result, queue empty", 1, 0);
      end else begin
        for (int k = 0; k < N; k++) begin
          int    ec, eu;
          string rq;
          ec = qCyc.pop_front();
          eu = qUnit.pop_front();
          rq = qReq.pop_front();
          chk(int'(cyc[k*CW +: CW]) == ec, rq, $sformatf("instr %0d cycle", k),
              int'(cyc[k*CW +: CW]), ec);
          chk(int'(unit[k*UW +: UW]) == eu, rq, $sformatf("instr %0d unit", k),
              int'(unit[k*UW +: UW]), eu);
        end
        begin
          int et;
          et = qTot.pop_front();
          chk(int'(tot) == et, "R8", "totalCycles", int'(tot), et);
        end
      end
      recheck = 1'b0;
    end
  end

  // start a run and measure the latency to done (R1)
  task automatic runWindow();
    int k;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 1;
    while (!done && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk(k == N + 1, "R1", "negedges from start to done", k, N + 1);
    @(negedge clk);
    chk(done == 1'b0, "R1", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; start4 = 1'b0;
    clearWin();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
    chk(tot == '0, "R10", "totalCycles after reset", int'(tot), 0);
    chk(cyc == '0, "R10", "issueCycle after reset", int'(cyc), 0);
    chk(unit == '0, "R10", "issueUnit after reset", int'(unit), 0);

    // mixed window with read-after-write chains steered onto producers (R3)
    clearWin();
    setI(0, 1, 1,  1, 2,  1, 3);
    setI(1, 1, 4,  1, 5,  0, 0);
    setI(2, 1, 7,  1, 1,  1, 9);
    setI(3, 1, 5,  1, 4,  1, 4);
    setI(4, 1, 1,  1, 12, 1, 10);
    setI(5, 0, 0,  1, 13, 1, 14);
    setI(6, 1, 15, 1, 14, 1, 12);
    pushWin('{0,0,1,1,2,2,3,3}, '{0,1,0,1,0,1,0,1}, 4, "R3");
    runWindow();

    // four-unit instance on the same window (R2 reordering, R6 unit range)
    @(negedge clk); start4 = 1'b1;
    @(negedge clk); start4 = 1'b0;
    begin
      int k;
      int ec4[N];
      int eu4[N];
      k = 0;
      while (!done4 && k < 50) begin
        @(negedge clk);
        k++;
      end
      ec4 = '{0,0,1,1,1,0,0,1};
      eu4 = '{0,1,0,1,2,2,3,3};
      for (int i = 0; i < N; i++) begin
        chk(int'(cyc4[i*CW +: CW]) == ec4[i], "R2", $sformatf("w4 instr %0d cycle", i),
            int'(cyc4[i*CW +: CW]), ec4[i]);
        chk(int'(unit4[i*UW4 +: UW4]) == eu4[i], "R6", $sformatf("w4 instr %0d unit", i),
            int'(unit4[i*UW4 +: UW4]), eu4[i]);
      end
      chk(int'(tot4) == 2, "R8", "w4 totalCycles", int'(tot4), 2);
    end

    // read-only sharing: no limits, lowest cycle then lowest unit (R2)
    clearWin();
    for (int k = 0; k < N; k++) setI(k, 1, k + 16, 1, 3, 1, 3);
    pushWin('{0,0,1,1,2,2,3,3}, '{0,1,0,1,0,1,0,1}, 4, "R2");
    runWindow();

    // full chain, longest schedule (R3, R8)
    clearWin();
    setI(0, 1, 1, 0, 0, 0, 0);
    for (int k = 1; k < N; k++) setI(k, 1, k + 1, 1, k, 0, 0);
    pushWin('{0,1,2,3,4,5,6,7}, '{0,0,0,0,0,0,0,0}, 8, "R3");
    runWindow();

    // write-after-read forbids an earlier slot; independent op jumps ahead (R4, R2)
    clearWin();
    setI(0, 1, 1, 1, 2, 0, 0);
    setI(1, 1, 3, 1, 1, 0, 0);
    setI(2, 1, 1, 1, 4, 0, 0);
    setI(3, 1, 7, 1, 8, 0, 0);
    pushWin('{0,1,1,0,2,2,3,3}, '{0,0,1,1,0,1,0,1}, 4, "R4");
    runWindow();

    // write-after-read in the same cycle is allowed (R4)
    clearWin();
    setI(0, 1, 10, 1, 5, 0, 0);
    setI(1, 1, 5,  1, 6, 0, 0);
    pushWin('{0,0,1,1,2,2,3,3}, '{0,1,0,1,0,1,0,1}, 4, "R4");
    runWindow();

    // write-after-write ordering and busy steered unit (R5, R6)
    clearWin();
    setI(0, 1, 1, 1, 2, 0, 0);
    setI(1, 1, 5, 1, 1, 0, 0);
    setI(2, 1, 5, 1, 3, 0, 0);
    setI(3, 1, 6, 1, 1, 0, 0);
    pushWin('{0,1,1,2,0,2,3,3}, '{0,0,1,0,1,1,0,1}, 4, "R5");
    runWindow();

    // invalid destination and invalid source fields ignored (R7)
    clearWin();
    setI(0, 0, 1, 1, 2, 0, 7);
    setI(1, 1, 3, 1, 1, 0, 0);
    setI(2, 1, 2, 1, 9, 0, 0);
    setI(3, 1, 8, 0, 2, 0, 0);
    pushWin('{0,0,1,1,2,2,3,3}, '{0,1,0,1,0,1,0,1}, 4, "R7");
    runWindow();

    // two producers: youngest one picks the unit (R3)
    clearWin();
    setI(0, 1, 1, 1, 10, 0, 0);
    setI(1, 1, 2, 1, 11, 0, 0);
    setI(2, 1, 5, 1, 1,  1, 2);
    pushWin('{0,0,1,1,2,2,3,3}, '{0,1,1,0,0,1,0,1}, 4, "R3");
    runWindow();

    // start during a run is ignored; captured window wins (R9)
    clearWin();
    for (int k = 0; k < N; k++) setI(k, 1, k + 16, 1, 3, 1, 3);
    pushWin('{0,0,1,1,2,2,3,3}, '{0,1,0,1,0,1,0,1}, 4, "R9");
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    clearWin();
    setI(0, 1, 1, 0, 0, 0, 0);
    for (int k = 1; k < N; k++) setI(k, 1, k + 1, 1, k, 0, 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int k;
      k = 0;
      while (!done && k < 50) begin
        @(negedge clk);
        k++;
      end
    end
    @(negedge clk);

    // outputs hold after done while inputs move (R9)
    clearWin();
    setI(0, 1, 1, 1, 2, 0, 0);
    setI(1, 1, 3, 1, 1, 0, 0);
    repeat (4) @(negedge clk);
    pushWin('{0,0,1,1,2,2,3,3}, '{0,1,0,1,0,1,0,1}, 4, "R9");
    @(posedge clk);
    recheck = 1'b1;
    @(negedge clk);
    @(negedge clk);

    chk(qTot.size() == 0, "R1", "results still pending", qTot.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule